// File: doc/BRIEF.md
# Frame Alignment Error Toggle Counter

This block watches the received frame alignment words of an E1-style link and turns them into a coarse bit-error-rate indication. The framer raises a strobe on each frame that should carry the alignment word and presents the seven received alignment bits alongside it. The block compares each word with the fixed expected pattern and counts the words that do not match. After a set number of errored words, it inverts a single status bit.

The status bit must not change faster than a minimum interval, so a hold-off timer runs on a frame-rate tick. The timer starts again at every inversion. When the error count reaches its limit during the hold-off, the count holds at the limit until the hold-off has expired. Software can estimate the error rate by sampling the bit over a known time and counting its inversions. With the default settings the bit inverts every 16 errored words and stays put for at least 1024 frame ticks, which is 128 ms at 125 µs frames. A debug output exposes the running count.

Top module: `fa_err_toggle`

## Requirements
- R1: The expected word is `fa_bits[6:0] == 7'b0011011`, where bit 6 is the first received bit. A strobed word equal to it leaves the count unchanged.
- R2: A strobed word that differs from the pattern in any number of bits, from one to seven, adds exactly one to the count.
- R3: While `fa_valid` is low, `fa_bits` has no effect on the count or on the status bit.
- R4: The count never exceeds `ERR_LIMIT`. Errored words that arrive while it is at `ERR_LIMIT` are dropped.
- R5: An inversion happens on a cycle where all three of these hold: `tick` is high, the count equals `ERR_LIMIT`, and no hold-off is pending. On the next clock, `err_flag` is inverted and the count becomes 0, or becomes 1 if that cycle also carried an errored word.
- R6: After an inversion, the next `HOLDOFF_TICKS` ticks cannot cause another inversion. The earliest possible next inversion is on tick number `HOLDOFF_TICKS`+1.
- R7: A synchronous active-high `rst` sets `err_flag` to 0 and the count to 0, and clears any pending hold-off.
- R8: `err_count` shows the count one clock after the strobe that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Frame-rate timebase pulse, one cycle per frame |
| fa_valid | input | 1 | Strobe that marks a received alignment word |
| fa_bits | input | 7 | Received alignment bits, bit 6 first |
| err_flag | output | 1 | Rate-limited status bit that inverts once per `ERR_LIMIT` errored words |
| err_count | output | $clog2(ERR_LIMIT+1) | Debug view of the errored-word count |

## Verification
The count and the status bit are both registered directly from the inputs. A strobe or tick presented before edge N therefore shows up on the ports just after edge N, with a latency of one clock. The bench drives inputs on the falling edge and samples on the next falling edge, so each result is read half a cycle after the edge that produced it. A behavioural model updates on every rising edge, and each sample is compared against it. Directed checks sample the ports at the same point after the saturation, hold-off and reset sequences.

// File: rtl/fa_err_toggle.sv
module fa_err_toggle #(
  parameter logic [6:0] PATTERN = 7'b0011011,
  parameter int ERR_LIMIT = 16,
  parameter int HOLDOFF_TICKS = 1024,
  localparam int CW = $clog2(ERR_LIMIT + 1),
  localparam int HW = $clog2(HOLDOFF_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          fa_valid,
  input  logic [6:0]    fa_bits,
  output logic          err_flag,
  output logic [CW-1:0] err_count
);

  localparam logic [CW-1:0] LIM  = CW'(ERR_LIMIT);
  localparam logic [HW-1:0] HOLD = HW'(HOLDOFF_TICKS);

  logic [CW-1:0] cnt;
  logic [HW-1:0] hold;
  logic          flag;

  wire bad     = fa_valid && (fa_bits != PATTERN);
  wire full    = (cnt == LIM);
  wire idle    = (hold == '0);
  wire flip    = tick && idle && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      hold <= '0;
      flag <= 1'b0;
    end else if (flip) begin
      flag <= ~flag;
      hold <= HOLD;
      cnt  <= bad ? CW'(1) : '0;
    end else begin
      if (tick && !idle) hold <= hold - 1'b1;
      if (bad && !full)  cnt  <= cnt + 1'b1;
    end
  end

  assign err_flag  = flag;
  assign err_count = cnt;

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);

  assert_reset_state_R7: assert property (@(posedge clk)
    rst |=> (!err_flag && err_count == '0 && hold == '0));

  assert_holdoff_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (hold != '0) |=> $stable(err_flag));

  assert_flip_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (!tick || !full) |=> $stable(err_flag));

  assert_ignore_nostrobe_R3: assert property (@(posedge clk) disable iff (rst)
    (!fa_valid && !flip) |=> $stable(err_count));

  assert_match_nocount_R1: assert property (@(posedge clk) disable iff (rst)
    (fa_valid && fa_bits == PATTERN && !flip) |=> $stable(err_count));

  assert_one_per_word_R2: assert property (@(posedge clk) disable iff (rst)
    (bad && !full && !flip) |=> (err_count == $past(cnt) + 1'b1));

endmodule

// File: tb/sim_fa_err_toggle.sv
module sim_fa_err_toggle;
  localparam int PERIOD = 10;
  localparam int LIMIT = 16;
  localparam int HOLDT = 20;
  localparam logic [6:0] PAT = 7'b0011011;
  localparam int CW = $clog2(LIMIT + 1);

  logic clk = 0, rst = 1, tick = 0, fa_valid = 0;
  logic [6:0] fa_bits = '0;
  logic err_flag;
  logic [CW-1:0] err_count;

  int compared = 0, mismatched = 0;
  int m_cnt = 0, m_hold = 0, m_flag = 0;
  string cur_req = "R7";

  always #(PERIOD/2) clk = ~clk;

  fa_err_toggle #(.PATTERN(PAT), .ERR_LIMIT(LIMIT), .HOLDOFF_TICKS(HOLDT)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .fa_valid(fa_valid), .fa_bits(fa_bits),
    .err_flag(err_flag), .err_count(err_count));

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_hold = 0; m_flag = 0;
    end else begin
      bit e;
      e = fa_valid && (fa_bits != PAT);
      if (tick && m_hold == 0 && m_cnt == LIMIT) begin
        m_flag = 1 - m_flag; m_hold = HOLDT; m_cnt = e ? 1 : 0;
      end else begin
        if (tick && m_hold > 0) m_hold--;
        if (e && m_cnt < LIMIT) m_cnt++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit t, input bit v, input logic [6:0] b);
    rst = r; tick = t; fa_valid = v; fa_bits = b;
    @(posedge clk);
    @(negedge clk);
    chk({cur_req, " R8 count"}, int'(err_count), m_cnt);
    chk("R5 R6 flag", int'(err_flag), m_flag);
  endtask

  initial begin
    #(PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired, all requirements: actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int f0;
    @(negedge clk);
    cur_req = "R7";
    repeat (3) step(1, 0, 0, '0);
    chk("R7 reset flag", int'(err_flag), 0);
    chk("R7 reset count", int'(err_count), 0);

    cur_req = "R1";
    repeat (5) step(0, 0, 1, PAT);
    chk("R1 matching words", int'(err_count), 0);

    cur_req = "R3";
    repeat (5) step(0, 0, 0, 7'b1100100);
    chk("R3 unstrobed bits", int'(err_count), 0);

    cur_req = "R2";
    step(0, 0, 1, PAT ^ 7'b0000001);
    chk("R2 one bit wrong", int'(err_count), 1);
    step(0, 0, 1, ~PAT);
    chk("R2 seven bits wrong", int'(err_count), 2);

    cur_req = "R4";
    repeat (20) step(0, 0, 1, 7'b1111111);
    chk("R4 saturate", int'(err_count), LIMIT);

    cur_req = "R5";
    f0 = int'(err_flag);
    step(0, 1, 1, 7'b0000000);
    chk("R5 toggled", int'(err_flag), 1 - f0);
    chk("R5 count restart", int'(err_count), 1);

    cur_req = "R6";
    repeat (20) step(0, 0, 1, 7'b1000000);
    for (int i = 0; i < HOLDT; i++) step(0, 1, 0, '0);
    chk("R6 held through hold-off", int'(err_flag), 1 - f0);
    step(0, 1, 0, '0);
    chk("R6 first tick after hold-off", int'(err_flag), f0);

    cur_req = "R5";
    for (int i = 0; i < 4000; i++)
      step(0, ($urandom_range(3) == 0), ($urandom_range(1) == 1),
           ($urandom_range(2) == 0) ? PAT : 7'($urandom));

    cur_req = "R7";
    step(1, 1, 1, 7'h7f);
    chk("R7 mid-run reset flag", int'(err_flag), 0);
    chk("R7 mid-run reset count", int'(err_count), 0);
    cur_req = "R5";
    repeat (LIMIT) step(0, 0, 1, 7'h00);
    step(0, 1, 0, '0);
    chk("R5 R7 no hold-off after reset", int'(err_flag), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule